// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

This block is a watchdog timer that counts a slow timebase: a one-cycle enable that arrives sixteen times per second. Software programs a single byte holding a timeout and a steering bit. The timeout is a five-bit multiplier scaled by a power of four. The steering bit decides what expiry does. With the bit set, expiry requests a system reset, wipes the watchdog byte and clears the century bit kept in a neighbouring register. With the bit clear, expiry raises one interrupt pulse.

Software services the watchdog in one of two ways. It can rewrite the byte, which restarts the countdown and clears the expiry flag. It can also simply read the byte, which reloads the countdown from the value already stored. The flag records that an expiry happened and stays set until the next write. The circuit that divides the system clock down to the sixteen-per-second enable is not part of this block.

Top module: `wdt_steer`

## Requirements
- R1: The timeout, counted in enable ticks, is N = 4^R × M. R is byte bits [1:0] and M is byte bits [6:2]. After a load, the N-th tick causes the expiry, and the expiry pulses appear in the cycle after that tick's clock edge.
- R2: A loaded value whose multiplier M is zero disables the timer, and this includes the value 0x00. No expiry then follows, however many ticks arrive.
- R3: A write stores the byte, which appears on `cfg_rdata` from the next cycle. The same write restarts the countdown and clears `wd_flag`.
- R4: A read strobe reloads the countdown from the stored byte and leaves `wd_flag` unchanged.
- R5: An expiry sets `wd_flag`. The flag stays set through further ticks and reads until the next write.
- R6: When bit 7 is set at expiry, `reset_req` and `century_clr` each pulse for exactly one cycle and the stored byte becomes 0x00. The timer then remains stopped, even after a read.
- R7: When bit 7 is clear at expiry, `irq_pulse` pulses for exactly one cycle and the byte is kept. The timer stops until the next write or read.
- R8: A write or read in the same cycle as the final tick wins. There is no expiry, and the countdown restarts from the full interval.
- R9: The countdown advances only on cycles where `tick_16hz` is high. Idle cycles never cause an expiry.
- R10: After reset, `wd_flag`, all pulse outputs and `cfg_rdata` are zero, and the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16hz | input | 1 | One-cycle enable at sixteen per second |
| cfg_wr | input | 1 | Write strobe for the watchdog byte |
| cfg_wdata | input | 8 | Write data: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution |
| cfg_rd | input | 1 | Read strobe; reloads the countdown |
| cfg_rdata | output | 8 | Current watchdog byte |
| wd_flag | output | 1 | Expiry flag |
| reset_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt |
| century_clr | output | 1 | One-cycle strobe that clears the neighbouring century bit |

## Verification
Two functions can land in the same cycle: servicing the watchdog (a write or a read) and the final tick of the countdown. The bench provokes this by asserting the strobe and `tick_16hz` together when exactly one tick remains. The outcome is judged correct only if no pulse follows at that point and the next expiry comes a full interval after the collision.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;

    localparam int unsigned RES_W   = 2;
    localparam int unsigned MULT_W  = 5;
    localparam int unsigned BYTE_W  = 1 + MULT_W + RES_W;
    localparam int unsigned MAX_SHL = 2 * ((1 << RES_W) - 1);
    localparam int unsigned CNT_W   = MULT_W + MAX_SHL;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    typedef logic [CNT_W-1:0] wd_cnt_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_RESET = 2'd2
    } wd_act_e;

    function automatic wd_cnt_t wd_interval(input wd_cfg_t c);
        return wd_cnt_t'(c.mult) << (2 * c.res);
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_steer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  wd_cfg_t wr_data,
    input  logic    clr,
    output wd_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data;
        else if (clr)   cfg_q <= '0;
    end

    // R6: a reset-steered expiry wipes the byte
    a_r6_byte_wiped: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> (cfg_q == '0));

    // R3: a write lands in the byte
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_q == $past(wr_data)));

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_steer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    load,
    input  wd_cfg_t load_cfg,
    output logic    expire,
    output logic    running
);

    wd_cnt_t cnt;
    wd_cnt_t reload;

    assign reload = wd_interval(load_cfg);
    assign expire = tick && running && !load && (cnt == wd_cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= reload;
            running <= (reload != '0);
        end else if (tick && running) begin
            if (cnt == wd_cnt_t'(1)) begin
                cnt     <= '0;
                running <= 1'b0;
            end else begin
                cnt <= cnt - wd_cnt_t'(1);
            end
        end
    end

    // R1: a running countdown never sits at zero
    a_r1_no_zero_run: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt != '0));

    // R9: without a tick or a load the count holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> ($stable(cnt) && $stable(running)));

    // R7: after an expiry the countdown is stopped
    a_r7_stops: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running);

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_steer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    input  logic flag_clr,
    output logic cfg_clr,
    output logic flag,
    output logic rst_req,
    output logic irq,
    output logic cent_clr
);

    wd_act_e act;

    always_comb begin
        act = ACT_NONE;
        if (expire) act = steer ? ACT_RESET : ACT_IRQ;
    end

    assign cfg_clr = (act == ACT_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            irq      <= 1'b0;
            cent_clr <= 1'b0;
            flag     <= 1'b0;
        end else begin
            rst_req  <= (act == ACT_RESET);
            cent_clr <= (act == ACT_RESET);
            irq      <= (act == ACT_IRQ);
            if (flag_clr)    flag <= 1'b0;
            else if (expire) flag <= 1'b1;
        end
    end

    // R6/R7: the two outcomes exclude each other
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq));

    // R6: reset request lasts one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R7: interrupt lasts one cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R5: a pulse always comes with the flag
    a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq) |-> flag);

    // R3: a write clears the flag
    a_r3_flag_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !flag);

endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
    import wdt_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16hz,
    input  logic              cfg_wr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              cfg_rd,
    output logic [BYTE_W-1:0] cfg_rdata,
    output logic              wd_flag,
    output logic              reset_req,
    output logic              irq_pulse,
    output logic              century_clr
);

    wd_cfg_t cfg_q;
    wd_cfg_t wr_cfg;
    wd_cfg_t load_cfg;
    logic    load;
    logic    expire;
    logic    running;
    logic    cfg_clr;

    assign wr_cfg    = wd_cfg_t'(cfg_wdata);
    assign load      = cfg_wr || cfg_rd;
    assign load_cfg  = cfg_wr ? wr_cfg : cfg_q;
    assign cfg_rdata = BYTE_W'(cfg_q);

    wdt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (wr_cfg),
        .clr     (cfg_clr),
        .cfg_q   (cfg_q)
    );

    wdt_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_16hz),
        .load     (load),
        .load_cfg (load_cfg),
        .expire   (expire),
        .running  (running)
    );

    wdt_action u_act (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .steer    (cfg_q.steer),
        .flag_clr (cfg_wr),
        .cfg_clr  (cfg_clr),
        .flag     (wd_flag),
        .rst_req  (reset_req),
        .irq      (irq_pulse),
        .cent_clr (century_clr)
    );

    // R8: servicing in a cycle suppresses any pulse after it
    a_r8_service_wins: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |=> !(reset_req || irq_pulse));

    // R6: the byte reads zero while the reset request is up
    a_r6_byte_zero: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (cfg_rdata == '0));

    // R6: the century strobe accompanies the reset request
    a_r6_century: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> century_clr);

    // R2: a stopped timer never produces a pulse
    a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> !(reset_req || irq_pulse));

endmodule

// File: tb/wdt_steer_test.sv
module wdt_steer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16hz = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_rd = 1'b0;
    logic [7:0] cfg_rdata;
    logic       wd_flag;
    logic       reset_req;
    logic       irq_pulse;
    logic       century_clr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // expected pulse code: {reset_req, irq_pulse, century_clr}
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    wdt_steer uut (
        .clk         (clk),
        .rst         (rst),
        .tick_16hz   (tick_16hz),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rd      (cfg_rd),
        .cfg_rdata   (cfg_rdata),
        .wd_flag     (wd_flag),
        .reset_req   (reset_req),
        .irq_pulse   (irq_pulse),
        .century_clr (century_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [7:0] d, input logic r);
        tick_16hz = t;
        cfg_wr    = w;
        cfg_wdata = d;
        cfg_rd    = r;
        @(negedge clk);
        tick_16hz = 1'b0;
        cfg_wr    = 1'b0;
        cfg_rd    = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic expect_pulse(input logic [2:0] code, input string req);
        exp_q.push_back(code);
        tag_q.push_back(req);
    endtask

    task automatic check_drained(input string req);
        #2;
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // monitor: every pulse must match the next expected item
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && (reset_req || irq_pulse || century_clr)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected pulse (R2/R7/R9)",
                          {reset_req, irq_pulse, century_clr}, 0);
                end else begin
                    logic [2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({reset_req, irq_pulse, century_clr} == e, t,
                          {reset_req, irq_pulse, century_clr}, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check({wd_flag, reset_req, irq_pulse, century_clr} == 4'b0, "R10 outputs",
              {wd_flag, reset_req, irq_pulse, century_clr}, 0);
        check(cfg_rdata == 8'h00, "R10 rdata", cfg_rdata, 0);
        rst = 1'b0;
        idle(2);
        ticks(20);
        check_drained("R10 stopped after reset");

        // R1/R3/R7: 0x05 -> M=1 R=1 -> 4 ticks, interrupt mode
        step(1'b0, 1'b1, 8'h05, 1'b0);
        check(cfg_rdata == 8'h05, "R3 stored", cfg_rdata, 8'h05);
        ticks(3);
        expect_pulse(3'b010, "R1 R7 irq after 4 ticks");
        ticks(1);
        check(wd_flag == 1'b1, "R5 flag set", wd_flag, 1);
        check(cfg_rdata == 8'h05, "R7 byte kept", cfg_rdata, 8'h05);
        ticks(10);
        check_drained("R7 stopped after irq");

        // R4: read reloads, flag untouched
        step(1'b0, 1'b0, 8'h00, 1'b1);
        check(wd_flag == 1'b1, "R4 flag kept by read", wd_flag, 1);
        ticks(3);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        ticks(3);
        check_drained("R4 reload postpones expiry");
        expect_pulse(3'b010, "R4 irq after reload");
        ticks(1);
        check_drained("R4 irq delivered");
        check(wd_flag == 1'b1, "R5 flag held", wd_flag, 1);

        // R6: 0x86 -> steer, M=1 R=2 -> 16 ticks
        step(1'b0, 1'b1, 8'h86, 1'b0);
        check(wd_flag == 1'b0, "R3 flag cleared by write", wd_flag, 0);
        ticks(15);
        expect_pulse(3'b101, "R6 reset and century");
        ticks(1);
        check(cfg_rdata == 8'h00, "R6 byte wiped", cfg_rdata, 0);
        check(wd_flag == 1'b1, "R5 flag on reset expiry", wd_flag, 1);
        ticks(30);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        ticks(30);
        check_drained("R6 stays stopped");
        check(wd_flag == 1'b1, "R5 flag survives reads", wd_flag, 1);

        // R2: disable by zero and by zero multiplier
        step(1'b0, 1'b1, 8'h09, 1'b0);
        ticks(5);
        step(1'b0, 1'b1, 8'h00, 1'b0);
        ticks(40);
        check_drained("R2 write zero disables");
        step(1'b0, 1'b1, 8'h83, 1'b0);
        ticks(100);
        check_drained("R2 zero multiplier disables");

        // R9: 0x04 -> 1 tick; idle cycles do nothing
        step(1'b0, 1'b1, 8'h04, 1'b0);
        idle(20);
        check_drained("R9 no tick no expiry");
        expect_pulse(3'b010, "R9 expiry on tick");
        ticks(1);
        check_drained("R9 delivered");

        // R8: write collides with final tick; 0x08 -> 2 ticks
        step(1'b0, 1'b1, 8'h08, 1'b0);
        ticks(1);
        step(1'b1, 1'b1, 8'h08, 1'b0);
        ticks(1);
        check_drained("R8 write wins over last tick");
        expect_pulse(3'b010, "R8 full interval after write");
        ticks(1);
        check_drained("R8 irq after write collision");

        // R8: read collides with final tick
        step(1'b0, 1'b0, 8'h00, 1'b1);
        ticks(1);
        step(1'b1, 1'b0, 8'h00, 1'b1);
        ticks(1);
        check_drained("R8 read wins over last tick");
        expect_pulse(3'b010, "R8 full interval after read");
        ticks(1);
        check_drained("R8 irq after read collision");

        // R1: largest interval 0x7F -> 64*31 = 1984 ticks
        step(1'b0, 1'b1, 8'h7F, 1'b0);
        ticks(1983);
        check_drained("R1 no early expiry at max");
        expect_pulse(3'b010, "R1 max interval");
        ticks(1);
        check_drained("R1 max delivered");

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule